// File: doc/BRIEF.md
# Reference Clock Frequency Auto-Detector

This block works out the nominal rate of an incoming reference clock by counting its rising edges over a fixed gate window. The window is timed by a stable master clock. The reference is first brought into the master domain through a multi-stage synchronizer and a rising-edge detector. At the end of each window the edge count is compared against expected counts, all derived at elaboration time from the master frequency and the window length. The result is one of eleven telecom nominal rates, a software-chosen custom rate that is a whole multiple of 8 kHz, or no match.

A classification becomes trusted only when two consecutive windows agree on it. Once trusted, the block also reports which loop-bandwidth class a downstream phase-locked loop should use for that reference: the narrowest class for the slowest rate, a middle class for 8 kHz, and the wide class for anything faster. A one-cycle update strobe marks every window result.

Top module: `ref_freq_detect`

## Requirements
- R1: While reset is asserted and after its release until the first window completes, freq_code is 0, freq_valid is 0, bw_sel is 0 and upd_stb is 0.
- R2: upd_stb pulses for exactly one master cycle once every GATE_CYCLES master cycles, and freq_code, freq_valid and bw_sel change only in cycles where upd_stb is high.
- R3: A window count within T = (E >> TOL_SHIFT) + TOL_ABS of an expected count E = round(f·GATE_CYCLES/MCLK_HZ) selects the nominal code. The codes are 1=2 kHz, 2=8 kHz, 3=64 kHz, 4=1.544 MHz, 5=2.048 MHz, 6=6.48 MHz, 7=8.192 MHz, 8=16.384 MHz, 9=19.44 MHz, 10=38.88 MHz and 11=77.76 MHz. An entry whose E is not greater than T is never matched.
- R4: With custom_mult = N > 0, a count within tolerance of the expected count for N·8 kHz gives code 12. Nominal entries take priority over the custom entry. N = 0 disables the custom entry.
- R5: A count that matches no entry gives freq_code 0 with freq_valid low.
- R6: A window with no reference rising edge gives freq_code 0 with freq_valid low.
- R7: freq_valid rises only when the same nonzero code is produced in two consecutive windows. It drops in the first window whose code differs from the previous one, and that window already shows the new code.
- R8: bw_sel is 0 while freq_valid is low. While freq_valid is high, bw_sel is 1 (14 Hz class) for code 1, 2 (56 Hz class) for code 2 or for code 12 with N = 1, and 3 (890 Hz class) for every other code.
- R9: Each reference rising edge is counted exactly once, for references up to a quarter of the master rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock that times the gate window |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock under measurement (asynchronous) |
| custom_mult | input | MULT_W | Custom rate as a multiple of 8 kHz; 0 disables it |
| freq_code | output | 4 | Detected rate code (0 = none) |
| freq_valid | output | 1 | Code confirmed by two consecutive windows |
| bw_sel | output | 2 | Loop-bandwidth class (0 none, 1 14 Hz, 2 56 Hz, 3 890 Hz) |
| upd_stb | output | 1 | One-cycle pulse when a window result is posted |

## Verification
Two events can land in the same master cycle: the closing cycle of a gate window and a detected reference edge. When they coincide, that edge has to be folded into the window being closed while the running counter restarts from zero. The bench provokes this with phase-accumulator references whose periods divide the window exactly (77.76 MHz against the 311.04 MHz master, and 2 kHz and 64 kHz against the slow-rate instance), so edges fall on every window boundary. It judges the outcome by the reported code, and by the loss or gain of confirmation in the windows that follow each rate change.

// File: rtl/refdet_pkg.sv
package refdet_pkg;

   localparam int CODE_W  = 4;
   localparam int NUM_NOM = 11;
   localparam int FRAC_W  = 16;

   localparam logic [CODE_W-1:0] CODE_NONE   = 4'd0;
   localparam logic [CODE_W-1:0] CODE_2K     = 4'd1;
   localparam logic [CODE_W-1:0] CODE_8K     = 4'd2;
   localparam logic [CODE_W-1:0] CODE_CUSTOM = 4'd12;

   typedef enum logic [1:0] {
      BW_NONE   = 2'd0,
      BW_NARROW = 2'd1,
      BW_MID    = 2'd2,
      BW_WIDE   = 2'd3
   } bw_e;

   // nominal rate in Hz for table slot idx (slot 0 -> code 1)
   function automatic logic [63:0] nom_hz(input int idx);
      case (idx)
         0:       return 64'd2_000;
         1:       return 64'd8_000;
         2:       return 64'd64_000;
         3:       return 64'd1_544_000;
         4:       return 64'd2_048_000;
         5:       return 64'd6_480_000;
         6:       return 64'd8_192_000;
         7:       return 64'd16_384_000;
         8:       return 64'd19_440_000;
         9:       return 64'd38_880_000;
         default: return 64'd77_760_000;
      endcase
   endfunction

   function automatic logic [63:0] exp_count(input logic [63:0] f_hz,
                                             input logic [63:0] gate,
                                             input logic [63:0] mclk);
      return (f_hz * gate + mclk / 2) / mclk;
   endfunction

   function automatic logic [63:0] tol_of(input logic [63:0] e,
                                          input int sh, input int ab);
      return (e >> sh) + 64'(ab);
   endfunction

   function automatic bw_e bw_for_code(input logic [CODE_W-1:0] c);
      if (c == CODE_NONE)     return BW_NONE;
      else if (c == CODE_2K)  return BW_NARROW;
      else if (c == CODE_8K)  return BW_MID;
      else                    return BW_WIDE;
   endfunction

endpackage

// File: rtl/refdet_sync_edge.sv
module refdet_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   output logic rise
);
   logic [SYNC_STAGES-1:0] stg;
   logic                   last_q;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= 1'b0;
               else        stg[0] <= ref_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[gi] <= 1'b0;
               else        stg[gi] <= stg[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= stg[SYNC_STAGES-1];

   assign rise = stg[SYNC_STAGES-1] & ~last_q;

   // R9: one edge yields exactly one count pulse
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/refdet_gate_counter.sv
module refdet_gate_counter #(
   parameter int GATE_CYCLES = 1024,
   parameter int CNT_W       = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic [CNT_W-1:0] meas_cnt,
   output logic             meas_stb
);
   localparam int GW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
   localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

   logic [GW-1:0]    gate_q;
   logic [CNT_W-1:0] edges_q;
   logic             at_end;

   assign at_end = (gate_q == LAST);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         gate_q   <= '0;
         edges_q  <= '0;
         meas_cnt <= '0;
         meas_stb <= 1'b0;
      end else begin
         meas_stb <= at_end;
         if (at_end) begin
            gate_q   <= '0;
            edges_q  <= '0;
            meas_cnt <= edges_q + CNT_W'(rise);
         end else begin
            gate_q  <= gate_q + 1'b1;
            edges_q <= edges_q + CNT_W'(rise);
         end
      end

   // R2: window results are spaced, never back to back
   a_r2_stb_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      meas_stb |=> !meas_stb);

endmodule

// File: rtl/refdet_classifier.sv
module refdet_classifier
   import refdet_pkg::*;
#(
   parameter longint unsigned MCLK_HZ     = 311_040_000,
   parameter int              GATE_CYCLES = 1024,
   parameter int              CNT_W       = 11,
   parameter int              TOL_SHIFT   = 5,
   parameter int              TOL_ABS     = 1,
   parameter int              MULT_W      = 16,
   parameter bit              CUSTOM_EN   = 1'b1
) (
   input  logic [CNT_W-1:0]  meas_cnt,
   input  logic [MULT_W-1:0] custom_mult,
   output logic [CODE_W-1:0] cls_code,
   output bw_e               cls_bw
);
   logic [63:0]        meas64;
   logic [NUM_NOM-1:0] nom_hit;
   logic               cust_hit;

   assign meas64 = 64'(meas_cnt);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_NOM; gi++) begin : g_nom
         localparam logic [63:0] EXPC = exp_count(nom_hz(gi), 64'(GATE_CYCLES), 64'(MCLK_HZ));
         localparam logic [63:0] TOLC = tol_of(EXPC, TOL_SHIFT, TOL_ABS);
         localparam bit          USED = (EXPC > TOLC);
         if (USED) begin : g_on
            assign nom_hit[gi] = (meas64 >= EXPC - TOLC) && (meas64 <= EXPC + TOLC);
         end else begin : g_off
            assign nom_hit[gi] = 1'b0;
         end
      end

      if (CUSTOM_EN) begin : g_cust
         localparam logic [63:0] STEP_Q =
            ((64'd8_000 * 64'(GATE_CYCLES)) << FRAC_W) / 64'(MCLK_HZ);
         logic [63:0] prod, exp_c, tol_c;
         always_comb begin
            prod  = 64'(custom_mult) * STEP_Q;
            exp_c = (prod + (64'd1 << (FRAC_W - 1))) >> FRAC_W;
            tol_c = (exp_c >> TOL_SHIFT) + 64'(TOL_ABS);
         end
         assign cust_hit = (custom_mult != '0) && (exp_c > tol_c) &&
                           (meas64 >= exp_c - tol_c) && (meas64 <= exp_c + tol_c);
      end else begin : g_nocust
         assign cust_hit = 1'b0;
      end
   endgenerate

   // lowest table slot wins, custom only when no nominal slot matches
   always_comb begin
      cls_code = CODE_NONE;
      if (cust_hit) cls_code = CODE_CUSTOM;
      for (int i = NUM_NOM - 1; i >= 0; i--)
         if (nom_hit[i]) cls_code = CODE_W'(i + 1);
      if (meas_cnt == '0) cls_code = CODE_NONE;
   end

   always_comb begin
      if (cls_code == CODE_CUSTOM)
         cls_bw = (custom_mult == MULT_W'(1)) ? BW_MID : BW_WIDE;
      else
         cls_bw = bw_for_code(cls_code);
   end

endmodule

// File: rtl/refdet_qualifier.sv
module refdet_qualifier
   import refdet_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              meas_stb,
   input  logic [CODE_W-1:0] cls_code,
   input  bw_e               cls_bw,
   output logic [CODE_W-1:0] code_o,
   output logic              valid_o,
   output bw_e               bw_o,
   output logic              upd_o
);
   logic agree;

   assign agree = (cls_code != CODE_NONE) && (cls_code == code_o);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         code_o  <= CODE_NONE;
         valid_o <= 1'b0;
         bw_o    <= BW_NONE;
         upd_o   <= 1'b0;
      end else begin
         upd_o <= meas_stb;
         if (meas_stb) begin
            code_o  <= cls_code;
            valid_o <= agree;
            bw_o    <= agree ? cls_bw : BW_NONE;
         end
      end

   // R2: outputs only move together with the update strobe
   a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |-> ($stable(code_o) && $stable(valid_o) && $stable(bw_o)));

   // R7: confirmation never comes with a code change
   a_r7_confirm_same: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $stable(code_o));

   // R5: a confirmed result always carries a real code
   a_r5_valid_code: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (code_o != CODE_NONE));

endmodule

// File: rtl/ref_freq_detect.sv
module ref_freq_detect
   import refdet_pkg::*;
#(
   parameter longint unsigned MCLK_HZ     = 311_040_000,
   parameter int              GATE_CYCLES = 311_040,
   parameter int              TOL_SHIFT   = 5,
   parameter int              TOL_ABS     = 1,
   parameter int              SYNC_STAGES = 2,
   parameter int              MULT_W      = 16,
   parameter bit              CUSTOM_EN   = 1'b1
) (
   input  logic              clk_m,
   input  logic              rst_n,
   input  logic              ref_in,
   input  logic [MULT_W-1:0] custom_mult,
   output logic [3:0]        freq_code,
   output logic              freq_valid,
   output logic [1:0]        bw_sel,
   output logic              upd_stb
);
   localparam int CNT_W = $clog2(GATE_CYCLES + 1) + 1;

   generate
      if (GATE_CYCLES < 2) begin : g_bad_gate
         $error("GATE_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MCLK_HZ == 0) begin : g_bad_mclk
         $error("MCLK_HZ must be nonzero");
      end
      if (TOL_SHIFT < 1 || TOL_SHIFT > 16) begin : g_bad_tol
         $error("TOL_SHIFT out of range");
      end
   endgenerate

   logic              rise;
   logic [CNT_W-1:0]  meas_cnt;
   logic              meas_stb;
   logic [CODE_W-1:0] cls_code;
   bw_e               cls_bw;
   bw_e               bw_q;

   refdet_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_m), .rst_n(rst_n), .ref_in(ref_in), .rise(rise));

   refdet_gate_counter #(.GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W)) u_gate (
      .clk(clk_m), .rst_n(rst_n), .rise(rise),
      .meas_cnt(meas_cnt), .meas_stb(meas_stb));

   refdet_classifier #(
      .MCLK_HZ(MCLK_HZ), .GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W),
      .TOL_SHIFT(TOL_SHIFT), .TOL_ABS(TOL_ABS), .MULT_W(MULT_W),
      .CUSTOM_EN(CUSTOM_EN)
   ) u_cls (
      .meas_cnt(meas_cnt), .custom_mult(custom_mult),
      .cls_code(cls_code), .cls_bw(cls_bw));

   refdet_qualifier u_qual (
      .clk(clk_m), .rst_n(rst_n), .meas_stb(meas_stb),
      .cls_code(cls_code), .cls_bw(cls_bw),
      .code_o(freq_code), .valid_o(freq_valid), .bw_o(bw_q), .upd_o(upd_stb));

   assign bw_sel = bw_q;

   // R6: an edgeless window can never post a code
   a_r6_silent_window: assert property (@(posedge clk_m) disable iff (!rst_n)
      (meas_stb && meas_cnt == '0) |=> (freq_code == CODE_NONE && !freq_valid));

   // R8: confirmed 2 kHz reference always selects the narrow class
   a_r8_narrow_bw: assert property (@(posedge clk_m) disable iff (!rst_n)
      (freq_valid && freq_code == CODE_2K) |-> (bw_sel == 2'd1));

   // R8: no bandwidth class without confirmation
   a_r8_none_unvalid: assert property (@(posedge clk_m) disable iff (!rst_n)
      !freq_valid |-> (bw_sel == 2'd0));

endmodule

// File: tb/ref_freq_detect_tb.sv
`timescale 1ns/1ps
module ref_freq_detect_tb;
   localparam int CLK_PERIOD = 10;
   localparam longint unsigned HI_MCLK = 311_040_000;
   localparam int              HI_GATE = 2000;
   localparam longint unsigned LO_MCLK = 512_000;
   localparam int              LO_GATE = 512;

   typedef struct {
      int    code;
      int    valid;
      int    bw;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] acc_hi = '0, acc_lo = '0, inc_hi = '0, inc_lo = '0;
   logic [15:0] mult_hi = '0, mult_lo = '0;
   logic [3:0]  code_hi, code_lo;
   logic        val_hi, val_lo, upd_hi, upd_lo;
   logic [1:0]  bw_hi, bw_lo;

   int vectors = 0;
   int fails   = 0;
   longint cyc = 0;
   longint last_hi = -1, last_lo = -1;
   exp_t q_hi[$];
   exp_t q_lo[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) begin
      cyc    <= cyc + 1;
      acc_hi <= acc_hi + inc_hi;
      acc_lo <= acc_lo + inc_lo;
   end

   ref_freq_detect #(.MCLK_HZ(HI_MCLK), .GATE_CYCLES(HI_GATE)) u_dut (
      .clk_m(clk), .rst_n(rst_n), .ref_in(acc_hi[31]), .custom_mult(mult_hi),
      .freq_code(code_hi), .freq_valid(val_hi), .bw_sel(bw_hi), .upd_stb(upd_hi));

   ref_freq_detect #(.MCLK_HZ(LO_MCLK), .GATE_CYCLES(LO_GATE)) u_dut_lo (
      .clk_m(clk), .rst_n(rst_n), .ref_in(acc_lo[31]), .custom_mult(mult_lo),
      .freq_code(code_lo), .freq_valid(val_lo), .bw_sel(bw_lo), .upd_stb(upd_lo));

   task automatic cmp(string tag, string what, longint act, longint expv);
      vectors++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   // monitors: pop expected results as the design posts them
   always @(negedge clk) if (rst_n && upd_hi) begin
      exp_t e;
      if (last_hi >= 0) cmp("R2", "hi strobe period", cyc - last_hi, HI_GATE);
      last_hi = cyc;
      if (q_hi.size() > 0) begin
         e = q_hi.pop_front();
         cmp(e.tag, "hi code",  code_hi, e.code);
         cmp(e.tag, "hi valid", val_hi,  e.valid);
         cmp(e.tag, "hi bw",    bw_hi,   e.bw);
      end
   end

   always @(negedge clk) if (rst_n && upd_lo) begin
      exp_t e;
      if (last_lo >= 0) cmp("R2", "lo strobe period", cyc - last_lo, LO_GATE);
      last_lo = cyc;
      if (q_lo.size() > 0) begin
         e = q_lo.pop_front();
         cmp(e.tag, "lo code",  code_lo, e.code);
         cmp(e.tag, "lo valid", val_lo,  e.valid);
         cmp(e.tag, "lo bw",    bw_lo,   e.bw);
      end
   end

   // driver: switch the reference at a window edge, queue two expected results
   task automatic drive(bit hi, longint unsigned f_hz, int mult, int code, int bw, string tag);
      longint unsigned m = hi ? HI_MCLK : LO_MCLK;
      logic [31:0] inc = 32'(((f_hz << 32) + m / 2) / m);
      exp_t e1, e2;
      e1 = '{code: code, valid: 0, bw: 0, tag: tag};
      e2 = '{code: code, valid: (code != 0), bw: (code != 0) ? bw : 0, tag: tag};
      if (hi) @(negedge clk iff upd_hi); else @(negedge clk iff upd_lo);
      @(posedge clk);
      if (hi) begin
         inc_hi  <= inc;
         mult_hi <= 16'(mult);
         q_hi.push_back(e1);
         q_hi.push_back(e2);
      end else begin
         inc_lo  <= inc;
         mult_lo <= 16'(mult);
         q_lo.push_back(e1);
         q_lo.push_back(e2);
      end
      repeat (2) begin
         if (hi) @(negedge clk iff upd_hi); else @(negedge clk iff upd_lo);
      end
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      cmp("R1", "hi code reset", code_hi, 0);
      cmp("R1", "hi valid reset", val_hi, 0);
      cmp("R1", "hi bw reset", bw_hi, 0);
      cmp("R1", "lo upd reset", upd_lo, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      cmp("R1", "hi code after release", code_hi, 0);
      cmp("R1", "lo valid after release", val_lo, 0);

      // slow-rate instance
      drive(0, 2_000,  0, 1,  1, "R3 R8 2k narrow");
      drive(0, 8_000,  1, 2,  2, "R4 R8 8k nominal beats custom");
      drive(0, 64_000, 0, 3,  3, "R3 R7 64k");
      drive(0, 16_000, 0, 0,  0, "R4 R5 custom disabled");
      drive(0, 16_000, 2, 12, 3, "R4 custom 16k");
      drive(0, 40_000, 2, 0,  0, "R5 off-nominal lo");
      drive(0, 0,      2, 0,  0, "R6 stopped lo");

      // fast-rate instance
      drive(1, 77_760_000, 0, 11, 3, "R9 R3 77.76M");
      drive(1, 38_880_000, 0, 10, 3, "R3 R7 38.88M");
      drive(1, 19_440_000, 0, 9,  3, "R3 19.44M");
      drive(1, 16_384_000, 0, 8,  3, "R3 16.384M");
      drive(1, 8_192_000,  0, 7,  3, "R3 8.192M");
      drive(1, 6_480_000,  0, 6,  3, "R3 6.48M");
      drive(1, 2_048_000,  0, 5,  3, "R3 2.048M");
      drive(1, 1_544_000,  0, 4,  3, "R3 1.544M");
      drive(1, 24_000_000, 3000, 12, 3, "R4 R8 custom 24M");
      drive(1, 30_000_000, 3000, 0,  0, "R5 off-nominal hi");
      drive(1, 0,          0, 0,  0, "R6 stopped hi");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(longint'(CLK_PERIOD) * 190_000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule